// File: doc/BRIEF.md
# Loop-Reuse Issue Queue Entry Array

This block is the storage array of an out-of-order issue queue, extended so that the instructions of a small loop can stay in the queue and be replayed. The array does not free such entries when they issue. A front end that has detected a short backward loop inserts its instructions with a hold flag. Each entry carries a hold bit, an issued bit, the logical register numbers (two sources and one destination), the physical register numbers and a program-order age tag.

During replay, the renamer overwrites the physical fields of a held entry in place, and that entry becomes ready to issue again. Two recovery commands exist. The first abandons buffering: it drops held entries that have already issued and releases the hold on every other entry. The second handles a mispredicted branch: it does the same work and also discards every entry younger than the branch. Age order is taken as distance from the current oldest age, so the tag may wrap.

Wakeup, select and the reorder buffer lie outside this block. It exposes per-entry status vectors and a combinational read port for the fields of one entry.

Top module: `iqr_array`

## Requirements
- R1: While reset is high and in the first cycle after it, every entry is invalid, `full` is 0 and `free_idx` is 0.
- R2: An accepted insert (`ins_valid` high, `full` low, no recovery command) writes the lowest-numbered invalid entry, which `free_idx` names. From the next cycle that entry is valid. It holds the given logical and physical fields and the age, its hold bit equals `ins_held`, and its issued bit is 0.
- R3: `full` is 1 exactly when all entries are valid. An insert while `full` is 1 changes nothing.
- R4: Issuing a valid held entry keeps it valid and sets its issued bit. The issued bit is never 1 on an entry that is not both valid and held.
- R5: Issuing a valid entry whose hold bit is 0 makes it invalid in the next cycle. An issue aimed at an invalid entry has no effect.
- R6: A rename of a valid entry replaces its three physical register numbers and clears its issued bit. The logical numbers, the age and the hold bit stay unchanged. A rename aimed at an invalid entry has no effect.
- R7: A revoke command (`rcv_revoke`) invalidates every entry that is valid, held and issued. It clears the hold bit of every entry and leaves all other fields unchanged.
- R8: A mispredict command (`rcv_mispred`, which wins over `rcv_revoke`) does the R7 work. It also invalidates every entry whose age is younger than `br_age`. Age a is younger than age b when (a − `head_age`) mod 64 > (b − `head_age`) mod 64. The branch's own age is not younger than itself.
- R9: In a cycle with a recovery command, the insert, issue and rename ports are ignored.
- R10: If issue and rename name the same entry in one cycle, only the issue acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_held | input | 1 | Hold the inserted entry after issue (loop buffering) |
| ins_lsrc_a | input | 5 | Logical source A of inserted instruction |
| ins_lsrc_b | input | 5 | Logical source B of inserted instruction |
| ins_ldst | input | 5 | Logical destination of inserted instruction |
| ins_psrc_a | input | 7 | Physical source A |
| ins_psrc_b | input | 7 | Physical source B |
| ins_pdst | input | 7 | Physical destination |
| ins_age | input | 6 | Program-order age tag |
| free_idx | output | 4 | Entry the next insert will take |
| full | output | 1 | No invalid entry remains |
| iss_valid | input | 1 | Issue-mark request |
| iss_idx | input | 4 | Entry being issued |
| ren_valid | input | 1 | Rename-update request |
| ren_idx | input | 4 | Entry being renamed |
| ren_psrc_a | input | 7 | New physical source A |
| ren_psrc_b | input | 7 | New physical source B |
| ren_pdst | input | 7 | New physical destination |
| rcv_revoke | input | 1 | Abandon buffering |
| rcv_mispred | input | 1 | Misprediction recovery |
| br_age | input | 6 | Age of the mispredicting branch |
| head_age | input | 6 | Age of the oldest instruction in flight |
| valid_vec | output | 16 | Valid bit per entry |
| held_vec | output | 16 | Hold bit per entry |
| issued_vec | output | 16 | Issued bit per entry |
| rd_idx | input | 4 | Entry selected on the read port |
| rd_lsrc_a | output | 5 | Logical source A of selected entry |
| rd_lsrc_b | output | 5 | Logical source B of selected entry |
| rd_ldst | output | 5 | Logical destination of selected entry |
| rd_psrc_a | output | 7 | Physical source A of selected entry |
| rd_psrc_b | output | 7 | Physical source B of selected entry |
| rd_pdst | output | 7 | Physical destination of selected entry |
| rd_age | output | 6 | Age of selected entry |

## Verification
The assertions need no promise from the environment about index ranges, because sixteen entries fill a 4-bit index exactly. They do assume that any issue, rename or insert sampled in a recovery cycle is to be discarded. The stimulus therefore drives all ports freely, including issue or rename aimed at invalid entries and commands overlapping recovery. Ages come from a wrapping counter and the head age is drawn at random, so the wrap arithmetic of R8 is exercised on both sides of zero.

// File: rtl/iqr_pkg.sv
`timescale 1ns/1ps
package iqr_pkg;

    localparam int LREG_W = 5;
    localparam int PREG_W = 7;
    localparam int AGE_W  = 6;

    typedef logic [LREG_W-1:0] lreg_t;
    typedef logic [PREG_W-1:0] preg_t;
    typedef logic [AGE_W-1:0]  age_t;

    typedef struct packed {
        lreg_t src_a;
        lreg_t src_b;
        lreg_t dst;
    } lregs_t;

    typedef struct packed {
        preg_t src_a;
        preg_t src_b;
        preg_t dst;
    } pregs_t;

    typedef struct packed {
        logic   valid;
        logic   held;
        logic   issued;
        lregs_t lr;
        pregs_t pr;
        age_t   age;
    } slot_t;

    typedef enum logic [1:0] {
        REC_NONE    = 2'd0,
        REC_REVOKE  = 2'd1,
        REC_MISPRED = 2'd2
    } rec_t;

    // Order by distance from the oldest in-flight age so the tag may wrap.
    function automatic logic is_younger(age_t a, age_t br, age_t head);
        age_t dist_a;
        age_t dist_b;
        dist_a = a - head;
        dist_b = br - head;
        return dist_a > dist_b;
    endfunction

endpackage

// File: rtl/iqr_free_pick.sv
`timescale 1ns/1ps
module iqr_free_pick #(
    parameter  int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] valid_vec,
    output logic [IDX_W-1:0] free_idx,
    output logic             full
);
    always_comb begin
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign full = &valid_vec;
endmodule

// File: rtl/iqr_slot.sv
`timescale 1ns/1ps
module iqr_slot
    import iqr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  rec_t   rec,
    input  age_t   br_age,
    input  age_t   head_age,
    input  logic   ld_en,
    input  logic   ld_held,
    input  lregs_t ld_lr,
    input  pregs_t ld_pr,
    input  age_t   ld_age,
    input  logic   iss_en,
    input  logic   ren_en,
    input  pregs_t ren_pr,
    output slot_t  q
);
    logic drop_on_rec;

    always_comb begin
        drop_on_rec = q.valid && ((q.held && q.issued) ||
                      ((rec == REC_MISPRED) && is_younger(q.age, br_age, head_age)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (rec != REC_NONE) begin
            if (drop_on_rec) begin
                q.valid  <= 1'b0;
                q.issued <= 1'b0;
            end
            q.held <= 1'b0;
        end else if (ld_en) begin
            q <= '{valid: 1'b1, held: ld_held, issued: 1'b0,
                   lr: ld_lr, pr: ld_pr, age: ld_age};
        end else if (q.valid && iss_en) begin
            if (q.held) begin
                q.issued <= 1'b1;
            end else begin
                q.valid  <= 1'b0;
                q.issued <= 1'b0;
            end
        end else if (q.valid && ren_en) begin
            q.pr     <= ren_pr;
            q.issued <= 1'b0;
        end
    end
endmodule

// File: rtl/iqr_read_mux.sv
`timescale 1ns/1ps
module iqr_read_mux
    import iqr_pkg::*;
#(
    parameter  int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  slot_t            slots [N_ENT],
    input  logic [IDX_W-1:0] idx,
    output lregs_t           lr,
    output pregs_t           pr,
    output age_t             age
);
    always_comb begin
        lr  = '0;
        pr  = '0;
        age = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (idx == IDX_W'(i)) begin
                lr  = slots[i].lr;
                pr  = slots[i].pr;
                age = slots[i].age;
            end
        end
    end
endmodule

// File: rtl/iqr_array.sv
`timescale 1ns/1ps
module iqr_array
    import iqr_pkg::*;
#(
    parameter  int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic              ins_held,
    input  logic [LREG_W-1:0] ins_lsrc_a,
    input  logic [LREG_W-1:0] ins_lsrc_b,
    input  logic [LREG_W-1:0] ins_ldst,
    input  logic [PREG_W-1:0] ins_psrc_a,
    input  logic [PREG_W-1:0] ins_psrc_b,
    input  logic [PREG_W-1:0] ins_pdst,
    input  logic [AGE_W-1:0]  ins_age,
    output logic [IDX_W-1:0]  free_idx,
    output logic              full,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_idx,
    input  logic              ren_valid,
    input  logic [IDX_W-1:0]  ren_idx,
    input  logic [PREG_W-1:0] ren_psrc_a,
    input  logic [PREG_W-1:0] ren_psrc_b,
    input  logic [PREG_W-1:0] ren_pdst,
    input  logic              rcv_revoke,
    input  logic              rcv_mispred,
    input  logic [AGE_W-1:0]  br_age,
    input  logic [AGE_W-1:0]  head_age,
    output logic [N_ENT-1:0]  valid_vec,
    output logic [N_ENT-1:0]  held_vec,
    output logic [N_ENT-1:0]  issued_vec,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LREG_W-1:0] rd_lsrc_a,
    output logic [LREG_W-1:0] rd_lsrc_b,
    output logic [LREG_W-1:0] rd_ldst,
    output logic [PREG_W-1:0] rd_psrc_a,
    output logic [PREG_W-1:0] rd_psrc_b,
    output logic [PREG_W-1:0] rd_pdst,
    output logic [AGE_W-1:0]  rd_age
);
    rec_t   rec;
    lregs_t ins_lr;
    pregs_t ins_pr;
    pregs_t ren_pr;
    slot_t  slots [N_ENT];
    lregs_t rd_lr;
    pregs_t rd_pr;
    logic   ins_ok;

    always_comb begin
        if (rcv_mispred)     rec = REC_MISPRED;
        else if (rcv_revoke) rec = REC_REVOKE;
        else                 rec = REC_NONE;
    end

    assign ins_lr = '{src_a: ins_lsrc_a, src_b: ins_lsrc_b, dst: ins_ldst};
    assign ins_pr = '{src_a: ins_psrc_a, src_b: ins_psrc_b, dst: ins_pdst};
    assign ren_pr = '{src_a: ren_psrc_a, src_b: ren_psrc_b, dst: ren_pdst};
    assign ins_ok = ins_valid && !full;

    iqr_free_pick #(.N_ENT(N_ENT)) u_pick (
        .valid_vec (valid_vec),
        .free_idx  (free_idx),
        .full      (full)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        logic hit_iss;
        assign hit_iss = iss_valid && (iss_idx == IDX_W'(g));

        iqr_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .rec      (rec),
            .br_age   (br_age),
            .head_age (head_age),
            .ld_en    (ins_ok && (free_idx == IDX_W'(g))),
            .ld_held  (ins_held),
            .ld_lr    (ins_lr),
            .ld_pr    (ins_pr),
            .ld_age   (ins_age),
            .iss_en   (hit_iss),
            .ren_en   (ren_valid && (ren_idx == IDX_W'(g)) && !hit_iss),
            .ren_pr   (ren_pr),
            .q        (slots[g])
        );

        assign valid_vec[g]  = slots[g].valid;
        assign held_vec[g]   = slots[g].held;
        assign issued_vec[g] = slots[g].issued;
    end

    iqr_read_mux #(.N_ENT(N_ENT)) u_rd (
        .slots (slots),
        .idx   (rd_idx),
        .lr    (rd_lr),
        .pr    (rd_pr),
        .age   (rd_age)
    );

    assign rd_lsrc_a = rd_lr.src_a;
    assign rd_lsrc_b = rd_lr.src_b;
    assign rd_ldst   = rd_lr.dst;
    assign rd_psrc_a = rd_pr.src_a;
    assign rd_psrc_b = rd_pr.src_b;
    assign rd_pdst   = rd_pr.dst;
endmodule

// File: rtl/iqr_array_chk.sv
`timescale 1ns/1ps
module iqr_array_chk #(
    parameter  int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             full,
    input logic [IDX_W-1:0] free_idx,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_idx,
    input logic             ren_valid,
    input logic [IDX_W-1:0] ren_idx,
    input logic             rcv_revoke,
    input logic             rcv_mispred,
    input logic [N_ENT-1:0] valid_vec,
    input logic [N_ENT-1:0] held_vec,
    input logic [N_ENT-1:0] issued_vec
);
    logic rcv;
    assign rcv = rcv_revoke || rcv_mispred;

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0 && !full));

    a_r2_insert_lands: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !full && !rcv) |=>
        (valid_vec[$past(free_idx)] && !issued_vec[$past(free_idx)]));

    a_r3_full_blocks_insert: assert property (@(posedge clk) disable iff (rst)
        (full && !rcv && !iss_valid) |=> (valid_vec == $past(valid_vec)));

    a_r4_held_issue_stays: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !rcv && valid_vec[iss_idx] && held_vec[iss_idx]) |=>
        (valid_vec[$past(iss_idx)] && issued_vec[$past(iss_idx)]));

    a_r4_issued_only_held: assert property (@(posedge clk) disable iff (rst)
        ((issued_vec & ~(valid_vec & held_vec)) == '0));

    a_r5_plain_issue_frees: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !rcv && valid_vec[iss_idx] && !held_vec[iss_idx]) |=>
        !valid_vec[$past(iss_idx)]);

    a_r6_rename_clears: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && !rcv && valid_vec[ren_idx] &&
         !(iss_valid && iss_idx == ren_idx)) |=> !issued_vec[$past(ren_idx)]);

    a_r7_hold_released: assert property (@(posedge clk) disable iff (rst)
        rcv |=> (held_vec == '0));

    a_r7_issued_held_dropped: assert property (@(posedge clk) disable iff (rst)
        rcv |=> ((valid_vec & $past(held_vec & issued_vec)) == '0));

    a_r9_no_alloc_in_recovery: assert property (@(posedge clk) disable iff (rst)
        rcv |=> ((valid_vec & ~$past(valid_vec)) == '0));

    a_r10_issue_wins: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && ren_valid && iss_idx == ren_idx && !rcv &&
         valid_vec[iss_idx] && held_vec[iss_idx]) |=> issued_vec[$past(iss_idx)]);
endmodule

bind iqr_array iqr_array_chk #(.N_ENT(N_ENT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ins_valid   (ins_valid),
    .full        (full),
    .free_idx    (free_idx),
    .iss_valid   (iss_valid),
    .iss_idx     (iss_idx),
    .ren_valid   (ren_valid),
    .ren_idx     (ren_idx),
    .rcv_revoke  (rcv_revoke),
    .rcv_mispred (rcv_mispred),
    .valid_vec   (valid_vec),
    .held_vec    (held_vec),
    .issued_vec  (issued_vec)
);

// File: tb/iqr_array_test.sv
`timescale 1ns/1ps
module iqr_array_test;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_valid = 0, ins_held = 0;
    logic [4:0] ins_lsrc_a = 0, ins_lsrc_b = 0, ins_ldst = 0;
    logic [6:0] ins_psrc_a = 0, ins_psrc_b = 0, ins_pdst = 0;
    logic [5:0] ins_age = 0;
    logic [3:0] free_idx;
    logic full;
    logic iss_valid = 0;
    logic [3:0] iss_idx = 0;
    logic ren_valid = 0;
    logic [3:0] ren_idx = 0;
    logic [6:0] ren_psrc_a = 0, ren_psrc_b = 0, ren_pdst = 0;
    logic rcv_revoke = 0, rcv_mispred = 0;
    logic [5:0] br_age = 0, head_age = 0;
    logic [N-1:0] valid_vec, held_vec, issued_vec;
    logic [3:0] rd_idx = 0;
    logic [4:0] rd_lsrc_a, rd_lsrc_b, rd_ldst;
    logic [6:0] rd_psrc_a, rd_psrc_b, rd_pdst;
    logic [5:0] rd_age;

    iqr_array uut (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model
    logic       m_v [N], m_h [N], m_i [N];
    logic [4:0] m_la [N], m_lb [N], m_ld [N];
    logic [6:0] m_pa [N], m_pb [N], m_pd [N];
    logic [5:0] m_age [N];
    logic [5:0] age_ctr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic younger(logic [5:0] a, logic [5:0] b, logic [5:0] h);
        logic [5:0] da, db;
        da = a - h;
        db = b - h;
        return da > db;
    endfunction

    function automatic int exp_free();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return 0;
    endfunction

    function automatic logic exp_full();
        for (int i = 0; i < N; i++) if (!m_v[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_h[i] = 0; m_i[i] = 0;
            m_la[i] = 0; m_lb[i] = 0; m_ld[i] = 0;
            m_pa[i] = 0; m_pb[i] = 0; m_pd[i] = 0; m_age[i] = 0;
        end
    endtask

    task automatic model_step();
        int  fi = exp_free();
        logic fl = exp_full();
        if (rcv_revoke || rcv_mispred) begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && ((m_h[i] && m_i[i]) ||
                    (rcv_mispred && younger(m_age[i], br_age, head_age)))) begin
                    m_v[i] = 0; m_i[i] = 0;
                end
                m_h[i] = 0;
            end
        end else begin
            if (iss_valid && m_v[iss_idx]) begin
                if (m_h[iss_idx]) m_i[iss_idx] = 1;
                else begin m_v[iss_idx] = 0; m_i[iss_idx] = 0; end
            end else if (ren_valid && m_v[ren_idx]) begin
                m_pa[ren_idx] = ren_psrc_a; m_pb[ren_idx] = ren_psrc_b;
                m_pd[ren_idx] = ren_pdst;   m_i[ren_idx] = 0;
            end
            if (ren_valid && m_v[ren_idx] && iss_valid && iss_idx != ren_idx) begin
                m_pa[ren_idx] = ren_psrc_a; m_pb[ren_idx] = ren_psrc_b;
                m_pd[ren_idx] = ren_pdst;   m_i[ren_idx] = 0;
            end
            if (ins_valid && !fl) begin
                m_v[fi] = 1; m_h[fi] = ins_held; m_i[fi] = 0;
                m_la[fi] = ins_lsrc_a; m_lb[fi] = ins_lsrc_b; m_ld[fi] = ins_ldst;
                m_pa[fi] = ins_psrc_a; m_pb[fi] = ins_psrc_b; m_pd[fi] = ins_pdst;
                m_age[fi] = ins_age;
            end
        end
    endtask

    task automatic check_state(input bit sweep);
        logic [N-1:0] ev, eh, ei;
        for (int i = 0; i < N; i++) begin ev[i] = m_v[i]; eh[i] = m_h[i]; ei[i] = m_i[i]; end
        chk(valid_vec == ev, "R2/R5/R8", "valid_vec", valid_vec, ev);
        chk(held_vec == eh, "R2/R7", "held_vec", held_vec, eh);
        chk(issued_vec == ei, "R4/R6/R10", "issued_vec", issued_vec, ei);
        chk(full == exp_full(), "R3", "full", full, exp_full());
        chk(int'(free_idx) == exp_free(), "R2", "free_idx", free_idx, exp_free());
        if (sweep) begin
            for (int i = 0; i < N; i++) begin
                if (!m_v[i]) continue;
                rd_idx = 4'(i);
                #0.1;
                chk({rd_lsrc_a, rd_lsrc_b, rd_ldst} == {m_la[i], m_lb[i], m_ld[i]},
                    "R6", "logical regs", {rd_lsrc_a, rd_lsrc_b, rd_ldst},
                    {m_la[i], m_lb[i], m_ld[i]});
                chk({rd_psrc_a, rd_psrc_b, rd_pdst} == {m_pa[i], m_pb[i], m_pd[i]},
                    "R6", "physical regs", {rd_psrc_a, rd_psrc_b, rd_pdst},
                    {m_pa[i], m_pb[i], m_pd[i]});
                chk(rd_age == m_age[i], "R2", "age", rd_age, m_age[i]);
            end
        end
    endtask

    task automatic clear_inputs();
        ins_valid = 0; iss_valid = 0; ren_valid = 0;
        rcv_revoke = 0; rcv_mispred = 0;
    endtask

    task automatic tick(input bit sweep);
        model_step();
        @(posedge clk);
        #1;
        clear_inputs();
        check_state(sweep);
    endtask

    task automatic set_ins(input logic held, input logic [5:0] age);
        ins_valid = 1; ins_held = held;
        ins_lsrc_a = 5'($urandom); ins_lsrc_b = 5'($urandom); ins_ldst = 5'($urandom);
        ins_psrc_a = 7'($urandom); ins_psrc_b = 7'($urandom); ins_pdst = 7'($urandom);
        ins_age = age;
    endtask

    task automatic set_ren(input logic [3:0] idx);
        ren_valid = 1; ren_idx = idx;
        ren_psrc_a = 7'($urandom); ren_psrc_b = 7'($urandom); ren_pdst = 7'($urandom);
    endtask

    task automatic do_reset();
        rst = 1;
        clear_inputs();
        model_reset();
        repeat (2) @(posedge clk);
        #1;
        chk(valid_vec == '0 && !full && free_idx == 0, "R1", "state in reset",
            {valid_vec, full, free_idx}, 0);
        rst = 0;
        @(posedge clk);
        #1;
        chk(valid_vec == '0 && !full && free_idx == 0, "R1", "state after reset",
            {valid_vec, full, free_idx}, 0);
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        do_reset();

        // R2/R3: fill, odd entries held
        for (int i = 0; i < N; i++) begin
            set_ins(i[0], 6'(i));
            tick(1);
        end
        chk(full == 1'b1, "R3", "full after fill", full, 1);
        set_ins(1'b1, 6'd40);
        tick(1); // R3 insert while full ignored

        // R4 issue held entry 1; R5 issue plain entry 0, then again (invalid)
        iss_valid = 1; iss_idx = 1; tick(1);
        chk(valid_vec[1] && issued_vec[1], "R4", "held issue", {valid_vec[1], issued_vec[1]}, 3);
        iss_valid = 1; iss_idx = 0; tick(1);
        chk(!valid_vec[0], "R5", "plain issue frees", valid_vec[0], 0);
        iss_valid = 1; iss_idx = 0; tick(1);
        set_ren(4'd0); tick(1); // R6 rename invalid entry ignored

        // R6 rename entry 1
        set_ren(4'd1); tick(1);
        chk(!issued_vec[1], "R6", "rename clears issued", issued_vec[1], 0);

        // R10 issue and rename same held entry 3
        iss_valid = 1; iss_idx = 3; set_ren(4'd3); tick(1);
        chk(issued_vec[3], "R10", "issue wins", issued_vec[3], 1);

        // R7/R9 revoke with concurrent insert and issue
        rcv_revoke = 1; set_ins(1'b1, 6'd50); iss_valid = 1; iss_idx = 5;
        tick(1);
        chk(!valid_vec[3] && valid_vec[1] && held_vec == '0, "R7", "revoke",
            {valid_vec[3], valid_vec[1], held_vec}, {2'b01, 16'h0});
        chk(!valid_vec[0], "R9", "insert ignored in recovery", valid_vec[0], 0);

        // R8 wraparound mispredict
        do_reset();
        for (int i = 0; i < 7; i++) begin
            set_ins(1'b1, 6'(60 + i));
            tick(1);
        end
        iss_valid = 1; iss_idx = 1; tick(1);
        rcv_mispred = 1; rcv_revoke = 1; br_age = 6'd63; head_age = 6'd60;
        tick(1);
        chk(valid_vec == 16'h000D, "R8", "wrap squash", valid_vec, 16'h000D);

        // Random phase
        age_ctr = 6'd8;
        for (int c = 0; c < 4000; c++) begin
            int r;
            if (($urandom % 100) < 60) begin set_ins(1'($urandom), age_ctr); age_ctr++; end
            if (($urandom % 100) < 40) begin iss_valid = 1; iss_idx = 4'($urandom); end
            if (($urandom % 100) < 30) set_ren(4'($urandom));
            r = int'($urandom % 100);
            head_age = age_ctr - 6'($urandom % 24);
            br_age = head_age + 6'($urandom % 24);
            if (r < 3) rcv_revoke = 1;
            else if (r < 6) rcv_mispred = 1;
            tick(c % 8 == 0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule